// File: doc/BRIEF.md
# Page Write Buffer with Self-Timed Commit

This block gathers the data bytes of one write transaction into an eight-slot page buffer and programs them into a 256 x 8 storage array only once the transaction is closed by a STOP. A bus front end opens a session with a start request that carries an 8-bit base word address. It then streams data bytes over a valid/ready interface and finally signals STOP or abort. The upper five bits of the base address select the page. The lower three bits give the first slot, and the slot pointer advances modulo eight with every accepted byte.

On a qualified STOP the block enters a self-timed program phase that lasts `TWR_CYCLES` clocks. `busy` is high for that whole phase, and the buffered bytes land in the array when the phase completes. The write-protect input cancels a session that it touches at any point from the first data byte up to STOP. If it rises during the program phase, the phase is cut short and the targeted locations are left erased. At commit the block reports the address of the last accepted byte, so that the bus front end can continue reading from there. A read port exposes the array contents.

Stream rules: a byte moves when `data_valid` and `data_ready` are both high on a clock edge. `data_ready` is low for the whole program phase and high at every other time. A byte accepted while no session is open is consumed and dropped. The source may hold `data_valid` high across cycles in which `data_ready` is low, and nothing moves in those cycles.

Top module: `page_write_commit`

## Requirements
- R1: After reset every array location reads FFh, `busy` and `commit_valid` are low, and `data_ready` is high.
- R2: Within a session, the k-th accepted byte (k from 0) is destined for address {base[7:3], (base[2:0]+k) mod 8}. Bits 7 to 3 never change during a session.
- R3: When more than eight bytes are accepted before STOP, the slot pointer wraps, and the array receives the last byte sent to each slot.
- R4: Only slots that received a byte are programmed. The other locations of the page keep their previous contents.
- R5: Nothing is programmed and `busy` stays low in three cases: the session is aborted, it receives no data before STOP, or it is replaced by a new start request before STOP. A replaced session's bytes are discarded.
- R6: `busy` rises in the cycle after a qualified STOP and stays high for exactly `TWR_CYCLES` cycles. The array shows the new bytes once `busy` has fallen.
- R7: If `wp` is high when any byte is accepted, or at any later cycle up to and including the STOP cycle, the session is cancelled. No program phase starts and the array is unchanged.
- R8: If `wp` is high during the program phase, `busy` falls on the next cycle. Every location that would have been programmed then reads FFh, and all other locations are unchanged.
- R9: While `busy` is high, `data_ready` is low, and start requests, data and STOP have no effect on the array or on the length of the phase.
- R10: `commit_valid` pulses for one cycle, in the first cycle of `busy`, with `commit_addr` equal to the address of the last accepted byte.
- R11: A session with a single byte writes exactly that one location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Open (or reopen) a write session |
| start_addr | input | 8 | Base word address of the session |
| data_valid | input | 1 | Data byte offered |
| data_ready | output | 1 | Byte accepted when high with data_valid |
| data_byte | input | 8 | Data byte |
| stop_evt | input | 1 | STOP seen on the bus, one-cycle pulse |
| abort_evt | input | 1 | Transfer ended without STOP, one-cycle pulse |
| wp | input | 1 | Write protect, high blocks programming |
| busy | output | 1 | Program phase in progress |
| commit_valid | output | 1 | One-cycle commit report |
| commit_addr | output | 8 | Address of the last accepted byte |
| rd_addr | input | 8 | Array read address |
| rd_data | output | 8 | Array contents at rd_addr (combinational) |

## Verification
The assertions assume the following about the inputs: `stop_evt`, `abort_evt` and `start_valid` are single-cycle pulses that never coincide with each other or with an accepted data byte, and `wp` is a level that may change on any cycle. The stimulus drives each control pulse alone on its own clock cycle, changes all inputs on the falling edge, and raises `wp` only at the points each protection case names. Bytes are offered on cycles free of control pulses, including during the program phase, to exercise the ignore rule.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    PW_IDLE = 2'd0,
    PW_FILL = 2'd1,
    PW_PROG = 2'd2
  } pw_state_e;
endpackage

// File: rtl/pwb_page_buf.sv
module pwb_page_buf #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 3,
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          open_i,
  input  logic [ADDR_W-1:0]             base_i,
  input  logic                          push_i,
  input  logic [DATA_W-1:0]             din_i,
  output logic [(1<<PAGE_W)*DATA_W-1:0] slots_o,
  output logic [(1<<PAGE_W)-1:0]        mask_o,
  output logic [ADDR_W-PAGE_W-1:0]      page_o,
  output logic [ADDR_W-1:0]             last_o,
  output logic                          any_o
);
  localparam int SLOTS = 1 << PAGE_W;
  localparam int HI_W  = ADDR_W - PAGE_W;

  logic [DATA_W-1:0] slot_q [SLOTS];
  logic [PAGE_W-1:0] ptr_q;
  logic [PAGE_W-1:0] last_q;
  logic [HI_W-1:0]   page_q;
  logic [SLOTS-1:0]  mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      last_q <= '0;
      page_q <= '0;
      mask_q <= '0;
    end else if (open_i) begin
      page_q <= base_i[ADDR_W-1:PAGE_W];
      ptr_q  <= base_i[PAGE_W-1:0];
      mask_q <= '0;
    end else if (push_i) begin
      mask_q[ptr_q] <= 1'b1;
      last_q        <= ptr_q;
      ptr_q         <= ptr_q + 1'b1;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[s] <= '0;
      end else if (push_i && !open_i && (ptr_q == PAGE_W'(s))) begin
        slot_q[s] <= din_i;
      end
    end
    assign slots_o[s*DATA_W +: DATA_W] = slot_q[s];
  end

  assign mask_o = mask_q;
  assign page_o = page_q;
  assign last_o = {page_q, last_q};
  assign any_o  = |mask_q;
endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int TWR_CYCLES = 625000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic byte_i,
  input  logic stop_i,
  input  logic abort_i,
  input  logic wp_i,
  input  logic any_i,
  output logic open_o,
  output logic push_o,
  output logic busy_o,
  output logic prog_we_o,
  output logic prog_erase_o,
  output logic commit_o
);
  localparam int CNT_W = $clog2(TWR_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TWR_CYCLES - 1);

  pw_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cancel_q;
  logic             commit_q;
  logic             in_fill;
  logic             go;

  assign in_fill = (state_q == PW_FILL);
  assign open_o  = start_i && !abort_i &&
                   ((state_q == PW_IDLE) || (in_fill && !stop_i));
  assign push_o  = in_fill && byte_i && !start_i && !stop_i && !abort_i;
  assign go      = in_fill && stop_i && !abort_i && any_i && !cancel_q && !wp_i;

  assign busy_o       = (state_q == PW_PROG);
  assign prog_erase_o = busy_o && wp_i;
  assign prog_we_o    = busy_o && (wp_i || (cnt_q == CNT_LAST));
  assign commit_o     = commit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PW_IDLE;
      cnt_q    <= '0;
      cancel_q <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      commit_q <= go;
      case (state_q)
        PW_IDLE: begin
          if (open_o) begin
            state_q  <= PW_FILL;
            cancel_q <= 1'b0;
          end
        end
        PW_FILL: begin
          if (abort_i) begin
            state_q <= PW_IDLE;
          end else if (stop_i) begin
            state_q <= go ? PW_PROG : PW_IDLE;
            cnt_q   <= '0;
          end else if (open_o) begin
            cancel_q <= 1'b0;
          end else begin
            cancel_q <= cancel_q | (wp_i & (any_i | push_o));
          end
        end
        PW_PROG: begin
          if (prog_we_o) begin
            state_q <= PW_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= PW_IDLE;
      endcase
    end
  end

  // R6: the phase begins only right after a STOP
  assert_busy_after_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_i));

  // R6 / R8: the phase ends only at full length or on protection
  assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> ($past(cnt_q) == CNT_LAST || $past(wp_i)));

  // R7: a protected stop never opens a program phase
  assert_wp_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fill && stop_i && wp_i) |=> !busy_o);

  // R8: protection during the phase ends it on the next cycle
  assert_wp_truncate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && wp_i) |=> !busy_o);

  // R5: a program phase always has buffered data behind it
  assert_prog_has_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> any_i);
endmodule

// File: rtl/pwb_array.sv
module pwb_array #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 3,
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we_i,
  input  logic                          erase_i,
  input  logic [ADDR_W-PAGE_W-1:0]      page_i,
  input  logic [(1<<PAGE_W)-1:0]        mask_i,
  input  logic [(1<<PAGE_W)*DATA_W-1:0] slots_i,
  input  logic [ADDR_W-1:0]             rd_addr_i,
  output logic [DATA_W-1:0]             rd_data_o
);
  localparam int SLOTS  = 1 << PAGE_W;
  localparam int HI_W   = ADDR_W - PAGE_W;
  localparam int NPAGES = 1 << HI_W;

  logic [DATA_W-1:0] col_rd [SLOTS];
  logic [HI_W-1:0]   rd_page;

  assign rd_page = rd_addr_i[ADDR_W-1:PAGE_W];

  for (genvar s = 0; s < SLOTS; s++) begin : g_col
    logic [DATA_W-1:0] col_q [NPAGES];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int p = 0; p < NPAGES; p++) col_q[p] <= '1;
      end else if (we_i && mask_i[s]) begin
        col_q[page_i] <= erase_i ? '1 : slots_i[s*DATA_W +: DATA_W];
      end
    end
    assign col_rd[s] = col_q[rd_page];
  end

  assign rd_data_o = col_rd[rd_addr_i[PAGE_W-1:0]];
endmodule

// File: rtl/page_write_commit.sv
module page_write_commit #(
  parameter int ADDR_W     = 8,
  parameter int PAGE_W     = 3,
  parameter int DATA_W     = 8,
  parameter int TWR_CYCLES = 625000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              data_valid,
  output logic              data_ready,
  input  logic [DATA_W-1:0] data_byte,
  input  logic              stop_evt,
  input  logic              abort_evt,
  input  logic              wp,
  output logic              busy,
  output logic              commit_valid,
  output logic [ADDR_W-1:0] commit_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int SLOTS = 1 << PAGE_W;
  localparam int HI_W  = ADDR_W - PAGE_W;

  logic                    open_s, push_s, any_s;
  logic                    we_s, erase_s;
  logic [SLOTS*DATA_W-1:0] slots_s;
  logic [SLOTS-1:0]        mask_s;
  logic [HI_W-1:0]         page_s;
  logic [ADDR_W-1:0]       last_s;

  assign data_ready = !busy;

  pwb_ctrl #(.TWR_CYCLES(TWR_CYCLES)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_valid),
    .byte_i       (data_valid && data_ready),
    .stop_i       (stop_evt),
    .abort_i      (abort_evt),
    .wp_i         (wp),
    .any_i        (any_s),
    .open_o       (open_s),
    .push_o       (push_s),
    .busy_o       (busy),
    .prog_we_o    (we_s),
    .prog_erase_o (erase_s),
    .commit_o     (commit_valid)
  );

  pwb_page_buf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .open_i  (open_s),
    .base_i  (start_addr),
    .push_i  (push_s),
    .din_i   (data_byte),
    .slots_o (slots_s),
    .mask_o  (mask_s),
    .page_o  (page_s),
    .last_o  (last_s),
    .any_o   (any_s)
  );

  pwb_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_arr (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (we_s),
    .erase_i   (erase_s),
    .page_i    (page_s),
    .mask_i    (mask_s),
    .slots_i   (slots_s),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  assign commit_addr = last_s;

  // R10: the commit report falls inside the program phase
  assert_commit_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> busy);

  // R10: the report is a single-cycle pulse
  assert_commit_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> !commit_valid);

  // R9: the buffer is frozen while programming
  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(mask_s) && $stable(page_s)));
endmodule

// File: tb/tb_page_write_commit.sv
module tb_page_write_commit;
  localparam int TWR = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_valid = 1'b0;
  logic [7:0] start_addr = '0;
  logic       data_valid = 1'b0;
  logic       data_ready;
  logic [7:0] data_byte = '0;
  logic       stop_evt = 1'b0;
  logic       abort_evt = 1'b0;
  logic       wp = 1'b0;
  logic       busy;
  logic       commit_valid;
  logic [7:0] commit_addr;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] exp_mem [256];

  always #4 clk = ~clk;

  page_write_commit #(.TWR_CYCLES(TWR)) dut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_addr(start_addr),
    .data_valid(data_valid), .data_ready(data_ready), .data_byte(data_byte),
    .stop_evt(stop_evt), .abort_evt(abort_evt), .wp(wp), .busy(busy),
    .commit_valid(commit_valid), .commit_addr(commit_addr),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int s, input int k);
    return 8'(s * 37 + k * 11 + 3);
  endfunction

  function automatic logic [7:0] slot_addr(input logic [7:0] base, input int k);
    return {base[7:3], 3'(int'(base[2:0]) + k)};
  endfunction

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic chk_page(input logic [7:0] base, input string req);
    logic [7:0] d;
    for (int s = 0; s < 8; s++) begin
      rd({base[7:3], 3'(s)}, d);
      chk(d == exp_mem[{base[7:3], 3'(s)}], req, d, exp_mem[{base[7:3], 3'(s)}]);
    end
  endtask

  task automatic pulse_start(input logic [7:0] a);
    @(negedge clk); start_valid = 1'b1; start_addr = a;
    @(negedge clk); start_valid = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); data_valid = 1'b1; data_byte = b;
    @(negedge clk); data_valid = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_evt = 1'b1;
    @(negedge clk); stop_evt = 1'b0;
  endtask

  task automatic pulse_abort();
    @(negedge clk); abort_evt = 1'b1;
    @(negedge clk); abort_evt = 1'b0;
  endtask

  // counts busy cycles after a stop, starting at the first busy sample
  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 4 * TWR) begin
      n++;
      @(negedge clk);
    end
  endtask

  // full page write with commit checks; updates the model
  task automatic page_write(input logic [7:0] base, input int n, input int seed, input string req);
    int len;
    pulse_start(base);
    for (int k = 0; k < n; k++) send(pat(seed, k));
    pulse_stop();
    chk(busy == 1'b1, "R6 busy after stop", busy, 1);
    chk(commit_valid == 1'b1, "R10 commit pulse", commit_valid, 1);
    chk(commit_addr == slot_addr(base, n - 1), "R10 commit addr", commit_addr, slot_addr(base, n - 1));
    count_busy(len);
    chk(len == TWR, "R6 busy length", len, TWR);
    for (int k = 0; k < n; k++) exp_mem[slot_addr(base, k)] = pat(seed, k);
    chk_page(base, req);
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int len;
    logic [7:0] b;
    for (int a = 0; a < 256; a++) exp_mem[a] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(commit_valid == 1'b0, "R1 commit_valid", commit_valid, 0);
    chk(data_ready == 1'b1, "R1 data_ready", data_ready, 1);
    for (int a = 0; a < 256; a++) begin
      rd(8'(a), d);
      chk(d == 8'hFF, "R1 erased", d, 8'hFF);
    end

    // R11 single byte write
    page_write(8'h5B, 1, 99, "R11 byte write");

    // R2 R3 R4 sweep over start offset and length
    for (int off = 0; off < 8; off++) begin
      for (int n = 1; n <= 10; n++) begin
        b = {5'((off * 10 + n) % 32), 3'(off)};
        page_write(b, n, off * 16 + n, (n > 8) ? "R3 wrap" : "R2 R4 page");
      end
    end

    // R5 abort discards
    pulse_start(8'h40);
    send(8'h11); send(8'h22);
    pulse_abort();
    pulse_stop();
    chk(busy == 1'b0, "R5 abort no busy", busy, 0);
    idle_cycles(TWR + 2);
    chk_page(8'h40, "R5 abort unchanged");

    // R5 stop with no data
    pulse_start(8'h48);
    pulse_stop();
    chk(busy == 1'b0, "R5 empty stop", busy, 0);

    // R5 replaced session: only the second is written
    pulse_start(8'h50);
    send(8'hA1); send(8'hA2);
    pulse_start(8'h63);
    send(8'hB1);
    pulse_stop();
    chk(commit_addr == 8'h63, "R5 replaced commit", commit_addr, 8'h63);
    count_busy(len);
    exp_mem[8'h63] = 8'hB1;
    chk_page(8'h50, "R5 replaced old page");
    chk_page(8'h60, "R5 replaced new page");

    // R7 wp high at the first byte
    pulse_start(8'h70);
    @(negedge clk); wp = 1'b1;
    send(8'h33);
    wp = 1'b0;
    send(8'h34);
    pulse_stop();
    chk(busy == 1'b0, "R7 wp first byte", busy, 0);
    chk_page(8'h70, "R7 unchanged");

    // R7 wp pulse between bytes and stop
    pulse_start(8'h78);
    send(8'h44); send(8'h45);
    @(negedge clk); wp = 1'b1;
    @(negedge clk); wp = 1'b0;
    pulse_stop();
    chk(busy == 1'b0, "R7 wp mid", busy, 0);
    chk_page(8'h78, "R7 unchanged mid");

    // R7 wp high on the stop cycle
    pulse_start(8'h80);
    send(8'h55);
    @(negedge clk); stop_evt = 1'b1; wp = 1'b1;
    @(negedge clk); stop_evt = 1'b0; wp = 1'b0;
    chk(busy == 1'b0, "R7 wp at stop", busy, 0);
    chk_page(8'h80, "R7 unchanged stop");

    // R8 truncation: new bytes over a programmed page give FFh
    page_write(8'h88, 8, 7, "R8 prep");
    pulse_start(8'h8A);
    send(8'h01); send(8'h02); send(8'h03);
    pulse_stop();
    chk(busy == 1'b1, "R8 busy start", busy, 1);
    idle_cycles(2);
    wp = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R8 truncated", busy, 0);
    wp = 1'b0;
    for (int k = 2; k < 5; k++) exp_mem[{5'h11, 3'(k)}] = 8'hFF;
    chk_page(8'h88, "R8 erased slots");

    // R9 requests during busy are ignored
    pulse_start(8'h90);
    send(8'hC0);
    pulse_stop();
    exp_mem[8'h90] = 8'hC0;
    chk(data_ready == 1'b0, "R9 ready low", data_ready, 0);
    start_valid = 1'b1; start_addr = 8'h91;
    @(negedge clk); start_valid = 1'b0;
    data_valid = 1'b1; data_byte = 8'hEE;
    @(negedge clk); data_valid = 1'b0;
    chk(data_ready == 1'b0, "R9 ready low later", data_ready, 0);
    stop_evt = 1'b1;
    @(negedge clk); stop_evt = 1'b0;
    count_busy(len);
    chk(len == TWR - 3, "R9 length kept", len, TWR - 3);
    idle_cycles(TWR + 2);
    chk(busy == 1'b0, "R9 no second phase", busy, 0);
    chk_page(8'h90, "R9 ignored data");

    // final full scan
    for (int a = 0; a < 256; a++) begin
      rd(8'(a), d);
      chk(d == exp_mem[a], "R4 final scan", d, exp_mem[a]);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule